// File: doc/BRIEF.md
# Five-Level Level-Shifted PWM Gate Modulator

This block turns a signed reference sample into the seven gate commands of a single-source, five-level boost inverter. The reference is held against four triangular carriers that share one phase. Each carrier sits in its own amplitude band, and the four bands are stacked one above the other without overlap. The comparator results add up to a signed output level from -2 to +2, which stands for an output of -4, -2, 0, +2 or +4 times the input voltage. Fixed Boolean logic derives six of the switch commands from the comparator bits. The boost switch follows a free-running 50% pulse train with its own period, and is held fully on only at the most negative level.

The gate commands are registered. Each one then passes through its own dead-time stage, which holds back a rising edge by a programmable number of clocks and passes a falling edge straight through. The carrier peak, the half-period of the boost pulse and the dead time are static configuration inputs. Another block supplies the reference sample. No closed-loop control is done here.

Top module: `lvl5_gate_modulator`

## Requirements
- R1: The carrier runs 0, 1, ..., P, P-1, ..., 1 and then repeats, so its period is 2*P clocks, where P is `carrierPeak` (P >= 1). The four carriers are this count plus -2P, -P, 0 and +P.
- R2: An upper comparator (bands 0..P and P..2P, named X1 and X2) is 1 when the reference is strictly above its carrier. A lower comparator (bands -P..0 and -2P..-P, named Y1 and Y2) is 1 when the reference is strictly below its carrier. The level is X1+X2-Y1-Y2.
- R3: `gates` bit i drives switch S(i+1): S2=Y2, S3=X2 or (level==0), S4=(X1 and not X2) or (Y1 and not Y2), S5=Y2, S6=X1, S7=Y1. At most one of S3 and S4 is on, and S2 and S6 are never on together.
- R4: When the level is not -2, S1 follows a square wave with high and low halves of `boostHalf` clocks each (period 2*`boostHalf`).
- R5: When the level is -2, S1 is held on continuously.
- R6: A change of the reference shows at `gates` two clocks later for a falling command. A rising command is delayed by `deadCycles` additional clocks. A command that is high for N clocks gives an output that is high for N-`deadCycles` clocks.
- R7: All gates are low while `rst` is high, and for 2*P clocks after it is released.
- R8: For a steady reference q with 0<q<P, S6 is high for 2q-1-`deadCycles` clocks of every carrier period, S3 for 2P-2q+1-`deadCycles`, and for reference -q S7 is high for 2q-1-`deadCycles`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| refSample | input | REF_W | Signed modulating reference, full scale +-2*carrierPeak |
| carrierPeak | input | CNT_W | Carrier peak count P, also the band height |
| boostHalf | input | BST_W | Half-period of the boost pulse train in clocks (>= 1) |
| deadCycles | input | DT_W | Rising-edge delay in clocks |
| gates | output | 7 | Gate outputs, bit i drives switch S(i+1) |

## Verification
The assertions assume that `carrierPeak`, `boostHalf` and `deadCycles` stay constant between resets, and that `carrierPeak` and `boostHalf` are at least one. The carrier bound and the band exclusivity depend on these assumptions. The bench sets all three before reset and leaves them untouched. It changes only `refSample`, and it holds each reference value for many carrier periods before it measures duty counts. It also keeps each reference either inside the ±2P range or clearly beyond it, so that the level it expects is fixed.

// File: rtl/lvl5_pkg.sv
package lvl5_pkg;
  typedef struct packed {
    logic gateEn;
    logic boostPulse;
  } tbStrobe_t;

  localparam int NUM_SW = 7;
  localparam logic [2:0] LVL_NEG2 = 3'b110;
  localparam logic [2:0] LVL_ZERO = 3'b000;
endpackage

// File: rtl/lvl5_timebase.sv
module lvl5_timebase
  import lvl5_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int BST_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] carrierPeak,
  input  logic [BST_W-1:0] boostHalf,
  output logic [CNT_W-1:0] triVal,
  output tbStrobe_t        strb
);
  localparam int HOLD_W = CNT_W + 1;

  logic             upQ;
  logic [CNT_W-1:0] triQ;
  logic [BST_W-1:0] bCnt;
  logic             pulseQ;
  logic [HOLD_W-1:0] holdCnt;
  logic             gateEnQ;
  logic [HOLD_W-1:0] holdLast;

  assign holdLast = {carrierPeak, 1'b0} - HOLD_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      triQ <= '0;
      upQ  <= 1'b1;
    end else if (upQ) begin
      triQ <= triQ + CNT_W'(1);
      if (triQ + CNT_W'(1) == carrierPeak) upQ <= 1'b0;
    end else begin
      triQ <= triQ - CNT_W'(1);
      if (triQ - CNT_W'(1) == '0) upQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bCnt   <= '0;
      pulseQ <= 1'b0;
    end else if (bCnt == boostHalf - BST_W'(1)) begin
      bCnt   <= '0;
      pulseQ <= ~pulseQ;
    end else begin
      bCnt <= bCnt + BST_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdCnt <= '0;
      gateEnQ <= 1'b0;
    end else if (!gateEnQ) begin
      if (holdCnt == holdLast) gateEnQ <= 1'b1;
      else holdCnt <= holdCnt + HOLD_W'(1);
    end
  end

  assign triVal          = triQ;
  assign strb.gateEn     = gateEnQ;
  assign strb.boostPulse = pulseQ;

  // R1
  tri_bound_chk: assert property (@(posedge clk) disable iff (rst)
    triQ <= carrierPeak);

  // R7
  gate_en_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    gateEnQ |=> gateEnQ);
endmodule

// File: rtl/lvl5_dead_gap.sv
module lvl5_dead_gap #(
  parameter int DT_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DT_W-1:0] deadCycles,
  input  logic            cmd,
  output logic            gate
);
  logic [DT_W-1:0] waitCnt;
  logic            gateQ;

  always_ff @(posedge clk) begin
    if (rst || !cmd) begin
      waitCnt <= '0;
      gateQ   <= 1'b0;
    end else if (waitCnt == deadCycles) begin
      gateQ <= 1'b1;
    end else begin
      waitCnt <= waitCnt + DT_W'(1);
    end
  end

  assign gate = gateQ;

  // R6
  no_early_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cmd) |-> !gateQ);
endmodule

// File: rtl/lvl5_switch_path.sv
module lvl5_switch_path
  import lvl5_pkg::*;
#(
  parameter int REF_W = 16,
  parameter int CNT_W = 12,
  parameter int DT_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] refSample,
  input  logic [CNT_W-1:0]        triVal,
  input  logic [CNT_W-1:0]        carrierPeak,
  input  logic [DT_W-1:0]         deadCycles,
  input  tbStrobe_t               strb,
  output logic [NUM_SW-1:0]       gates
);
  localparam int CW = REF_W + 2;
  localparam int NBAND = 4;

  logic signed [CW-1:0] refExt, triExt, pkExt;
  logic signed [CW-1:0] carrier [NBAND];
  logic [NBAND-1:0]     above, below;
  logic                 x1, x2, y1, y2;
  logic [2:0]           levelNow;
  logic [NUM_SW-1:0]    cmdNext, cmdQ;

  assign refExt = {{(CW-REF_W){refSample[REF_W-1]}}, refSample};
  assign triExt = {{(CW-CNT_W){1'b0}}, triVal};
  assign pkExt  = {{(CW-CNT_W){1'b0}}, carrierPeak};

  always_comb begin
    carrier[0] = triExt - (pkExt <<< 1);
    carrier[1] = triExt - pkExt;
    carrier[2] = triExt;
    carrier[3] = triExt + pkExt;
  end

  for (genvar k = 0; k < NBAND; k++) begin : g_cmp
    assign above[k] = refExt > carrier[k];
    assign below[k] = refExt < carrier[k];
  end

  assign x1 = above[2];
  assign x2 = above[3];
  assign y1 = below[1];
  assign y2 = below[0];

  assign levelNow = 3'(x1) + 3'(x2) - 3'(y1) - 3'(y2);

  always_comb begin
    cmdNext    = '0;
    cmdNext[0] = (levelNow == LVL_NEG2) ? 1'b1 : strb.boostPulse;
    cmdNext[1] = y2;
    cmdNext[2] = x2 | (levelNow == LVL_ZERO);
    cmdNext[3] = (x1 & ~x2) | (y1 & ~y2);
    cmdNext[4] = y2;
    cmdNext[5] = x1;
    cmdNext[6] = y1;
    if (!strb.gateEn) cmdNext = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cmdQ <= '0;
    else     cmdQ <= cmdNext;
  end

  for (genvar s = 0; s < NUM_SW; s++) begin : g_dead
    lvl5_dead_gap #(.DT_W(DT_W)) u_gap (
      .clk       (clk),
      .rst       (rst),
      .deadCycles(deadCycles),
      .cmd       (cmdQ[s]),
      .gate      (gates[s])
    );
  end

  // R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.gateEn |=> cmdQ == '0);

  // R3
  mid_pair_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmdQ[2], cmdQ[3]}));

  // R3
  s2_s6_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmdQ[1] && cmdQ[5]));

  // R5
  bottom_boost_on_chk: assert property (@(posedge clk) disable iff (rst)
    cmdQ[1] |-> cmdQ[0]);
endmodule

// File: rtl/lvl5_gate_modulator.sv
module lvl5_gate_modulator
  import lvl5_pkg::*;
#(
  parameter int REF_W = 16,
  parameter int CNT_W = 12,
  parameter int BST_W = 12,
  parameter int DT_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] refSample,
  input  logic [CNT_W-1:0]        carrierPeak,
  input  logic [BST_W-1:0]        boostHalf,
  input  logic [DT_W-1:0]         deadCycles,
  output logic [6:0]              gates
);
  tbStrobe_t        strb;
  logic [CNT_W-1:0] triVal;

  lvl5_timebase #(.CNT_W(CNT_W), .BST_W(BST_W)) u_timebase (
    .clk        (clk),
    .rst        (rst),
    .carrierPeak(carrierPeak),
    .boostHalf  (boostHalf),
    .triVal     (triVal),
    .strb       (strb)
  );

  lvl5_switch_path #(.REF_W(REF_W), .CNT_W(CNT_W), .DT_W(DT_W)) u_path (
    .clk        (clk),
    .rst        (rst),
    .refSample  (refSample),
    .triVal     (triVal),
    .carrierPeak(carrierPeak),
    .deadCycles (deadCycles),
    .strb       (strb),
    .gates      (gates)
  );
endmodule

// File: tb/lvl5_gate_modulator_bench.sv
module lvl5_gate_modulator_bench;
  localparam int PK = 20;
  localparam int BH = 7;
  localparam int DT = 3;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic signed [15:0] refSample = '0;
  logic [11:0]        carrierPeak = 12'(PK);
  logic [11:0]        boostHalf = 12'(BH);
  logic [9:0]         deadCycles = 10'(DT);
  logic [6:0]         gates;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lvl5_gate_modulator u_lvl5_gate_modulator (
    .clk(clk), .rst(rst), .refSample(refSample), .carrierPeak(carrierPeak),
    .boostHalf(boostHalf), .deadCycles(deadCycles), .gates(gates)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic countHigh(input int bitIdx, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gates[bitIdx]) cnt++;
    end
  endtask

  task automatic testReset();
    ticks(3);
    chk("R7 gates low in reset", int'(gates), 0);
    refSample = 16'sd45;
    rst = 1'b0;
    ticks(2 * PK);
    chk("R7 gates low during startup hold", int'(gates), 0);
    ticks(20);
  endtask

  task automatic testTopLevel();
    int c;
    refSample = 16'sd45;
    ticks(20);
    chk("R3 level +2 gates S2..S7", int'(gates[6:1]), 6'b010010);
    countHigh(0, 2 * BH, c);
    chk("R4 S1 pulse high count at +2", c, BH - DT);
  endtask

  task automatic testBottomLevel();
    int c;
    refSample = -16'sd45;
    ticks(20);
    chk("R5 R3 level -2 gates", int'(gates), 7'b1010011);
    countHigh(0, 2 * BH, c);
    chk("R5 S1 held on at -2", c, 2 * BH);
  endtask

  task automatic testZeroLevel();
    int c;
    refSample = 16'sd0;
    ticks(20);
    chk("R3 level 0 gates S2..S7", int'(gates[6:1]), 6'b000010);
    countHigh(0, 2 * BH, c);
    chk("R4 S1 pulse high count at 0", c, BH - DT);
  endtask

  task automatic testMidPos();
    int c;
    refSample = 16'sd8;
    ticks(4 * PK);
    countHigh(5, 2 * PK, c);
    chk("R8 S6 duty ref +8", c, 2 * 8 - 1 - DT);
    countHigh(3, 2 * PK, c);
    chk("R2 S4 duty ref +8", c, 2 * 8 - 1 - DT);
    countHigh(2, 2 * PK, c);
    chk("R8 S3 duty ref +8", c, 2 * PK - 2 * 8 + 1 - DT);
    countHigh(1, 2 * PK, c);
    chk("R3 S2 off ref +8", c, 0);
  endtask

  task automatic testPeriod();
    int c;
    refSample = 16'sd8;
    ticks(10);
    while (gates[5]) @(negedge clk);
    while (!gates[5]) @(negedge clk);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (gates[5]);
    while (!gates[5]) begin
      @(negedge clk);
      c++;
    end
    chk("R1 carrier period in clocks", c, 2 * PK);
  endtask

  task automatic testMidNeg();
    int c;
    refSample = -16'sd8;
    ticks(4 * PK);
    countHigh(6, 2 * PK, c);
    chk("R8 S7 duty ref -8", c, 2 * 8 - 1 - DT);
    countHigh(3, 2 * PK, c);
    chk("R2 S4 duty ref -8", c, 2 * 8 - 1 - DT);
    countHigh(5, 2 * PK, c);
    chk("R2 S6 off ref -8", c, 0);
  endtask

  task automatic testDeadEdges();
    refSample = -16'sd45;
    ticks(20);
    refSample = 16'sd45;
    ticks(1);
    chk("R6 S2 still high after one clock", int'(gates[1]), 1);
    ticks(1);
    chk("R6 S2 falls after two clocks", int'(gates[1]), 0);
    ticks(DT - 1);
    chk("R6 S6 held back by dead time", int'(gates[5]), 0);
    ticks(1);
    chk("R6 S6 rises after dead time", int'(gates[5]), 1);
  endtask

  initial begin
    testReset();
    testTopLevel();
    testBottomLevel();
    testZeroLevel();
    testMidPos();
    testPeriod();
    testMidNeg();
    testDeadEdges();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule